// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. A divided clock advances a measurement frame of fixed length through three phases in a fixed order: auto-zero, signal integrate and reference de-integrate. The block drives one-hot phase selects to the analog switches. At the end of integration it captures the input polarity from the comparator, which also selects the reference sign applied while de-integrating. It then counts de-integrate time in a decimal (BCD) counter until the comparator reports that the integrator is back at zero.

Signal integrate always lasts `INT_COUNTS` counts. De-integrate may use up to `DEINT_MAX` counts. Auto-zero takes whatever is left, so every frame is `CYCLE_COUNTS` counts long whatever the input. When de-integrate finishes, the reading, its sign and an overrange flag are copied into a display latch unless the hold input is high. Conversions keep running while hold is high. The comparator is asynchronous to the block and passes through a two-flop synchronizer.

Top module: `adc_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge and right after it, `phase_sel` is 3'b001 (auto-zero), `ref_neg`, `disp_neg` and `disp_over` are 0 and `disp_bcd` is all zeros.
- R2: `phase_sel` has exactly one bit set: bit 0 is auto-zero, bit 1 is signal integrate and bit 2 is de-integrate. It only ever moves auto-zero to integrate, integrate to de-integrate, and de-integrate to auto-zero.
- R3: One count is `CLK_DIV` clocks. Phase changes happen only on count boundaries, and signal integrate lasts exactly `INT_COUNTS` counts.
- R4: Successive entries into signal integrate are exactly `CYCLE_COUNTS` counts apart, whatever the reading. The first frame after reset begins with an auto-zero of `CYCLE_COUNTS - INT_COUNTS - DEINT_MAX` counts.
- R5: At the last count of integrate, `ref_neg` takes the inverse of the synchronized comparator (comparator low means a negative input). It stays unchanged until the next such point.
- R6: De-integrate ends at the first count where the synchronized comparator differs from the value captured at the end of integrate. The reading is the number of de-integrate counts before that count.
- R7: If no crossing has been seen after `DEINT_MAX` counts, de-integrate ends with the reading saturated at `DEINT_MAX` and `disp_over` set. A crossing clears `disp_over`.
- R8: When de-integrate ends with `hold` low, the display latch takes the reading, its sign (`disp_neg` equals `ref_neg`) and the overrange flag. With `hold` high the latch keeps its value while frames keep running.
- R9: `disp_bcd` holds one BCD digit per 4-bit field, with the units digit in bits [3:0], the tens digit in [7:4], and so on upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_in | input | 1 | Raw comparator output, high when the integrator is above zero |
| hold | input | 1 | High keeps the display latch unchanged |
| phase_sel | output | 3 | One-hot phase select: [0] auto-zero, [1] integrate, [2] de-integrate |
| ref_neg | output | 1 | Polarity captured at the end of integrate, selects the reference sign |
| disp_bcd | output | 4*DIGITS | Latched reading, BCD, units in the low nibble |
| disp_neg | output | 1 | Latched sign of the reading |
| disp_over | output | 1 | Latched overrange flag |

## Verification
A wrong phase or position state shows on `phase_sel` within one count (`CLK_DIV` clocks). It also moves the start of the next integrate, which breaks the fixed frame spacing at the next frame boundary. A corrupted BCD count, a wrong polarity capture or a mishandled saturation shows only when the display latch loads at the end of that frame's de-integrate. The bench therefore compares the latch against an independent model after every conversion and on every clock. A hold fault shows as a latch change during a frame in which hold was high.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DE  = 2'd2
    } phase_e;

    // Binary to packed BCD, up to eight digits, units in the low nibble.
    function automatic logic [31:0] bin2bcd(input int value);
        logic [31:0] res;
        int          rem;
        res = '0;
        rem = value;
        for (int k = 0; k < 8; k++) begin
            res[4*k +: 4] = 4'(rem % 10);
            rem = rem / 10;
        end
        return res;
    endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end

    assign tick_o = (div_q == LAST);
endmodule

// File: rtl/adc_seq_sync.sv
module adc_seq_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[0], async_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign sync_o = sh_q[1];
endmodule

// File: rtl/adc_seq_bcd.sv
module adc_seq_bcd #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  inc_i,
    output logic [4*DIGITS-1:0]   count_o
);
    localparam int BCD_W = 4 * DIGITS;

    logic [BCD_W-1:0] cnt_d, cnt_q;
    logic [DIGITS:0]  carry;

    assign carry[0] = inc_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_decade
        logic [3:0] cur;
        logic       at_nine;
        assign cur          = cnt_q[4*g +: 4];
        assign at_nine      = (cur == 4'd9);
        assign carry[g+1]   = carry[g] & at_nine;
        assign cnt_d[4*g +: 4] = clr_i    ? 4'd0 :
                                 carry[g] ? (at_nine ? 4'd0 : cur + 4'd1) :
                                            cur;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int INT_COUNTS   = 1000,
    parameter int DEINT_MAX    = 2000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int DIGITS       = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                comp_in,
    input  logic                hold,
    output logic [2:0]          phase_sel,
    output logic                ref_neg,
    output logic [4*DIGITS-1:0] disp_bcd,
    output logic                disp_neg,
    output logic                disp_over
);
    localparam int BCD_W = 4 * DIGITS;
    localparam int POS_W = $clog2(CYCLE_COUNTS);
    localparam logic [POS_W-1:0] POS_INT_LAST = POS_W'(INT_COUNTS - 1);
    localparam logic [POS_W-1:0] POS_DE_LAST  = POS_W'(INT_COUNTS + DEINT_MAX - 1);
    localparam logic [POS_W-1:0] POS_AZ_FIRST = POS_W'(INT_COUNTS + DEINT_MAX);
    localparam logic [POS_W-1:0] POS_LAST     = POS_W'(CYCLE_COUNTS - 1);
    localparam logic [31:0]      SAT_ALL      = bin2bcd(DEINT_MAX);
    localparam logic [BCD_W-1:0] SAT_BCD      = SAT_ALL[BCD_W-1:0];

    typedef struct packed {
        phase_e           phase;
        logic [POS_W-1:0] pos;
        logic             neg;
        logic [BCD_W-1:0] disp;
        logic             dneg;
        logic             dover;
    } seq_t;

    seq_t             st_d, st_q;
    logic             tick_w;
    logic             comp_s;
    logic             bcd_clr, bcd_inc;
    logic [BCD_W-1:0] bcd_cnt;

    adc_seq_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick_w)
    );

    adc_seq_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (comp_in),
        .sync_o  (comp_s)
    );

    adc_seq_bcd #(.DIGITS(DIGITS)) u_bcd (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (bcd_clr),
        .inc_i   (bcd_inc),
        .count_o (bcd_cnt)
    );

    always_comb begin
        logic             finish;
        logic             over;
        logic [BCD_W-1:0] reading;
        st_d    = st_q;
        bcd_clr = 1'b0;
        bcd_inc = 1'b0;
        finish  = 1'b0;
        over    = 1'b0;
        reading = bcd_cnt;
        if (tick_w) begin
            unique case (st_q.phase)
                PH_AZ: begin
                    if (st_q.pos == POS_LAST) begin
                        st_d.phase = PH_INT;
                        st_d.pos   = '0;
                    end else begin
                        st_d.pos   = st_q.pos + 1'b1;
                    end
                end
                PH_INT: begin
                    st_d.pos = st_q.pos + 1'b1;
                    if (st_q.pos == POS_INT_LAST) begin
                        st_d.phase = PH_DE;
                        st_d.neg   = ~comp_s;
                        bcd_clr    = 1'b1;
                    end
                end
                PH_DE: begin
                    st_d.pos = st_q.pos + 1'b1;
                    if (comp_s == st_q.neg) begin
                        finish  = 1'b1;
                    end else begin
                        bcd_inc = 1'b1;
                        if (st_q.pos == POS_DE_LAST) begin
                            finish  = 1'b1;
                            over    = 1'b1;
                            reading = SAT_BCD;
                        end
                    end
                end
                default: st_d.phase = PH_AZ;
            endcase
        end
        if (finish) begin
            st_d.phase = PH_AZ;
            if (!hold) begin
                st_d.disp  = reading;
                st_d.dneg  = st_q.neg;
                st_d.dover = over;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_AZ;
            st_q.pos   <= POS_AZ_FIRST;
            st_q.neg   <= 1'b0;
            st_q.disp  <= '0;
            st_q.dneg  <= 1'b0;
            st_q.dover <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        phase_sel = 3'b000;
        unique case (st_q.phase)
            PH_AZ:   phase_sel = 3'b001;
            PH_INT:  phase_sel = 3'b010;
            PH_DE:   phase_sel = 3'b100;
            default: phase_sel = 3'b001;
        endcase
    end

    assign ref_neg   = st_q.neg;
    assign disp_bcd  = st_q.disp;
    assign disp_neg  = st_q.dneg;
    assign disp_over = st_q.dover;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
    parameter int DIGITS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                hold,
    input logic                tick,
    input logic [2:0]          phase_sel,
    input logic                ref_neg,
    input logic [4*DIGITS-1:0] disp_bcd,
    input logic                disp_neg,
    input logic                disp_over
);
    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_sel) == 1);

    assert_az_next_R2: assert property (@(posedge clk) disable iff (rst)
        ((phase_sel != $past(phase_sel)) && $past(phase_sel[0])) |-> phase_sel[1]);

    assert_int_next_R2: assert property (@(posedge clk) disable iff (rst)
        ((phase_sel != $past(phase_sel)) && $past(phase_sel[1])) |-> phase_sel[2]);

    assert_de_next_R2: assert property (@(posedge clk) disable iff (rst)
        ((phase_sel != $past(phase_sel)) && $past(phase_sel[2])) |-> phase_sel[0]);

    assert_count_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_sel != $past(phase_sel)) |-> $past(tick));

    assert_refneg_moves_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_neg) |-> $rose(phase_sel[2]));

    assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(disp_bcd) && $stable(disp_neg) && $stable(disp_over)));
endmodule

bind adc_seq_top adc_seq_checker #(.DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .tick      (tick_w),
    .phase_sel (phase_sel),
    .ref_neg   (ref_neg),
    .disp_bcd  (disp_bcd),
    .disp_neg  (disp_neg),
    .disp_over (disp_over)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 4;
    localparam int INTC = 100;
    localparam int DMAX = 200;
    localparam int CYC  = 400;
    localparam int DIG  = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            comp_in = 1'b1;
    logic            hold = 1'b0;
    logic [2:0]      phase_sel;
    logic            ref_neg;
    logic [4*DIG-1:0] disp_bcd;
    logic            disp_neg;
    logic            disp_over;

    adc_seq_top #(.CLK_DIV(DIV), .INT_COUNTS(INTC), .DEINT_MAX(DMAX),
                  .CYCLE_COUNTS(CYC), .DIGITS(DIG)) i_adc_seq_top (
        .clk(clk), .rst(rst), .comp_in(comp_in), .hold(hold),
        .phase_sel(phase_sel), .ref_neg(ref_neg), .disp_bcd(disp_bcd),
        .disp_neg(disp_neg), .disp_over(disp_over));

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int m_div, m_phase, m_pos, m_cnt, m_disp;
    bit m_neg, m_dneg, m_dover, m_s1, m_s2, end_evt;
    // stimulus: signed reading the analog front end represents
    int vin = 137;
    bit hold_v = 1'b0;
    // port-timing bookkeeping
    int clk_no = 0;
    int last_int_start = -1;
    int int_len = 0;
    logic [2:0] prev_sel = 3'b001;

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int t;
        t = v;
        for (int k = 0; k < 4; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, got, got, exp, exp);
        end
    endtask

    function automatic bit comp_model();
        bit   pos_in;
        int   mag;
        pos_in = (vin >= 0);
        mag    = (vin < 0) ? -vin : vin;
        if (m_phase == 2) return pos_in ^ (m_cnt >= mag);
        return pos_in;
    endfunction

    task automatic model_reset();
        m_div = 0; m_phase = 0; m_pos = INTC + DMAX; m_cnt = 0;
        m_disp = 0; m_neg = 0; m_dneg = 0; m_dover = 0;
        m_s1 = 0; m_s2 = 0;
    endtask

    task automatic model_edge();
        bit tick, fin, ovr;
        int rd;
        end_evt = 0;
        if (rst) begin
            model_reset();
            return;
        end
        tick = (m_div == DIV - 1);
        m_div = (m_div + 1) % DIV;
        fin = 0; ovr = 0; rd = 0;
        if (tick) begin
            case (m_phase)
                0: if (m_pos == CYC - 1) begin m_phase = 1; m_pos = 0; end
                   else m_pos++;
                1: begin
                    if (m_pos == INTC - 1) begin
                        m_phase = 2; m_neg = !m_s2; m_cnt = 0;
                    end
                    m_pos++;
                end
                default: begin
                    if (m_s2 == m_neg) begin
                        fin = 1; rd = m_cnt;
                    end else begin
                        m_cnt++;
                        if (m_pos == INTC + DMAX - 1) begin
                            fin = 1; ovr = 1; rd = DMAX;
                        end
                    end
                    m_pos++;
                end
            endcase
        end
        if (fin) begin
            m_phase = 0;
            end_evt = 1;
            if (!hold_v) begin
                m_disp = rd; m_dneg = m_neg; m_dover = ovr;
            end
        end
        m_s2 = m_s1;
        m_s1 = comp_in;
    endtask

    task automatic compare_ports();
        logic [2:0] exp_sel;
        exp_sel = (m_phase == 0) ? 3'b001 : (m_phase == 1) ? 3'b010 : 3'b100;
        check(phase_sel == exp_sel, "R2", "phase_sel", phase_sel, exp_sel);
        check(ref_neg == m_neg, "R5", "ref_neg", ref_neg, m_neg);
        check(disp_bcd == to_bcd(m_disp), "R9", "disp_bcd", disp_bcd, to_bcd(m_disp));
        check(disp_neg == m_dneg, "R8", "disp_neg", disp_neg, m_dneg);
        check(disp_over == m_dover, "R7", "disp_over", disp_over, m_dover);
        // frame timing measured at the ports only
        if (!rst) begin
            if (phase_sel == 3'b010 && prev_sel != 3'b010) begin
                if (last_int_start >= 0)
                    check(clk_no - last_int_start == CYC * DIV, "R4",
                          "clocks between integrate starts",
                          clk_no - last_int_start, CYC * DIV);
                last_int_start = clk_no;
                int_len = 0;
            end
            if (phase_sel == 3'b010) int_len++;
            if (phase_sel == 3'b100 && prev_sel == 3'b010)
                check(int_len == INTC * DIV, "R3", "integrate length in clocks",
                      int_len, INTC * DIV);
        end
        prev_sel = phase_sel;
    endtask

    task automatic step();
        @(posedge clk);
        clk_no++;
        model_edge();
        @(negedge clk);
        compare_ports();
        comp_in = comp_model();
        hold    = hold_v;
    endtask

    task automatic convert(input int v_next, input bit hold_next);
        do step(); while (!end_evt);
        vin    = v_next;
        hold_v = hold_next;
    endtask

    task automatic expect_disp(input string req, input int mag, input bit neg,
                               input bit ovr);
        check(disp_bcd == to_bcd(mag), req, "reading", disp_bcd, to_bcd(mag));
        check(disp_neg == neg, req, "sign", disp_neg, neg);
        check(disp_over == ovr, req, "overrange", disp_over, ovr);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        model_reset();
        for (int i = 0; i < 3; i++) step();
        // R1: reset state
        check(phase_sel == 3'b001, "R1", "phase_sel in reset", phase_sel, 3'b001);
        check(disp_bcd == '0, "R1", "disp_bcd in reset", disp_bcd, 0);
        check({ref_neg, disp_neg, disp_over} == 3'b000, "R1", "flags in reset",
              {ref_neg, disp_neg, disp_over}, 0);
        rst = 1'b0;
        step();
        check(phase_sel == 3'b001, "R1", "phase_sel after reset", phase_sel, 3'b001);

        // R6 R9: positive reading, digit fields
        convert(-58, 1'b0);
        expect_disp("R6", 137, 1'b0, 1'b0);
        check(disp_bcd[7:4] == 4'd3, "R9", "tens field", disp_bcd[7:4], 3);
        check(disp_bcd[11:8] == 4'd1, "R9", "hundreds field", disp_bcd[11:8], 1);
        // R5: negative input
        convert(0, 1'b0);
        expect_disp("R5", 58, 1'b1, 1'b0);
        convert(199, 1'b0);
        expect_disp("R6", 0, 1'b0, 1'b0);
        convert(-200, 1'b0);
        expect_disp("R6", 199, 1'b0, 1'b0);
        // R7: saturation
        convert(250, 1'b0);
        expect_disp("R7", 200, 1'b1, 1'b1);
        convert(42, 1'b1);
        expect_disp("R7", 200, 1'b0, 1'b1);
        // R8: hold freezes latch for two frames
        convert(-7, 1'b1);
        expect_disp("R8", 200, 1'b0, 1'b1);
        convert(91, 1'b0);
        expect_disp("R8", 200, 1'b0, 1'b1);
        convert(1, 1'b0);
        expect_disp("R8", 91, 1'b0, 1'b0);
        convert(1, 1'b0);
        expect_disp("R6", 1, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule